// File: doc/BRIEF.md
# Reset Cause Collector

This block merges four internal reasons for restarting the chip into a single synchronous system reset, and it keeps a status byte that records which reason caused the most recent restart. The four reasons are a watchdog timeout, a flash access violation, a software request, and a USB event. A USB event is either a bus reset signalled while the USB function is enabled, or a change of level on the VBUS input. USB events can restart the chip only when software has selected USB as a reset source.

The watchdog sits inside the block. A clock-enable divider advances it once every `CLK_DIV` system cycles. A kick strobe reloads it to `WDT_LOAD`. Software can stop it through a control write, and every system reset the block generates starts it again. Each reset is a pulse exactly `RST_LEN` cycles long, and it touches no external reset pin.

Software reaches the block through a one-bit-address write port. Address 0 is the status byte and address 1 is watchdog control. The status byte can be read at all times on `stat_rdata`.

Top module: `reset_cause_hub`

## Requirements
- R1: While `pwr_rst_n` is low and after it is released, `sys_rst` is 0 and `stat_rdata` is 0x00, and the watchdog is running.
- R2: With no kick and no other reset, `sys_rst` rises on rising edge number CLK_DIV*(WDT_LOAD+1) after the watchdog restarts, counting the first edge after the restart as edge 1. With the defaults this is 192.
- R3: A watchdog reset makes `stat_rdata` read 0x20: bit 5 set, all other bits clear.
- R4: A kick strobe reloads the watchdog and restarts its divider, so kicking at intervals shorter than the R2 window never causes a reset.
- R5: Writing address 1 with bit 0 = 1 stops the watchdog, and writing bit 0 = 0 starts it again. Any reset the block generates re-enables the watchdog and restarts it from a full load.
- R6: A one-cycle `flash_err` pulse raises `sys_rst` on the next edge, after which `stat_rdata` reads 0x40 (bit 6 only).
- R7: Writing address 0 with bit 4 = 1 raises `sys_rst` on that write edge, after which `stat_rdata` reads 0x10 (bit 4 only).
- R8: Bit 7 of address 0 is the USB source enable, and it reads back as written. A `usb_bus_rst` causes a reset only when bit 7 is 1 and `usb_func_en` is 1, and that reset leaves `stat_rdata` at 0x80. Any reset from another cause clears bit 7.
- R9: With bit 7 set, a rising or a falling change on `vbus` makes `sys_rst` rise on the third edge that sees the new level, after a two-flop synchronizer.
- R10: `sys_rst` stays high for exactly RST_LEN (4) cycles. During the pulse, all causes and all bus writes are ignored, and `stat_rdata` does not change.
- R11: When causes arrive in the same cycle, exactly one status flag is set, chosen in the order watchdog, flash, software, USB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_rst_n | input | 1 | Chip power-on reset, active low, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0: status byte, 1: watchdog control |
| bus_wdata | input | 8 | Write data |
| wdt_kick | input | 1 | Watchdog refresh strobe |
| flash_err | input | 1 | Flash access violation pulse |
| usb_func_en | input | 1 | USB function enabled |
| usb_bus_rst | input | 1 | USB bus reset signalling detected |
| vbus | input | 1 | VBUS level, asynchronous |
| sys_rst | output | 1 | System reset pulse, active high |
| stat_rdata | output | 8 | Status byte: bit 7 USB, bit 6 flash, bit 5 watchdog, bit 4 software |

## Verification
The bench measures the exact watchdog expiry edge. It does this once from power-up and again after the watchdog has been disabled and then re-armed by a software reset, so an off-by-one in the divide-by-12 divider or the load count shows up as a shifted edge. It steps `vbus` both up and down and expects the reset on the third edge. A design that detected only one polarity, or that skipped a synchronizer stage, would miss a reset or fire it a cycle early. It injects a flash pulse during an active reset pulse and also fires flash together with a software write. A design that re-armed the pulse would stretch it, and one with the wrong priority would leave the wrong flag or two flags set. It also checks that the USB enable drops after a non-USB reset, because a design that kept it would let a later VBUS change restart the chip unexpectedly.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned BIT_SW  = 4;
  localparam int unsigned BIT_USB = 7;

  // field order mirrors status bits 7..4
  typedef struct packed {
    logic usb;
    logic flash;
    logic wdt;
    logic sw;
  } cause_t;

  // fixed priority: watchdog, flash, software, usb
  function automatic cause_t pick_cause(cause_t r);
    cause_t w;
    w = '0;
    if (r.wdt)        w.wdt   = 1'b1;
    else if (r.flash) w.flash = 1'b1;
    else if (r.sw)    w.sw    = 1'b1;
    else if (r.usb)   w.usb   = 1'b1;
    return w;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(cause_t s);
    return {s, 4'b0000};
  endfunction
endpackage

// File: rtl/rsc_wdog.sv
module rsc_wdog #(
  parameter int unsigned DIV  = 12,
  parameter int unsigned LOAD = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic kick,
  input  logic cfg_we,
  input  logic cfg_dis,
  output logic expire
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned CW = $clog2(LOAD + 1);

  logic [PW-1:0] pre;
  logic [CW-1:0] cnt;
  logic          en;
  logic          last_tick;

  function automatic logic [PW-1:0] next_pre(logic [PW-1:0] p, logic wrap);
    return wrap ? '0 : p + 1'b1;
  endfunction

  assign last_tick = (pre == PW'(DIV - 1));
  assign expire    = en && last_tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b1;
      pre <= '0;
      cnt <= CW'(LOAD);
    end else if (hold) begin
      en  <= 1'b1;
      pre <= '0;
      cnt <= CW'(LOAD);
    end else begin
      if (cfg_we) en <= !cfg_dis;
      if (kick) begin
        pre <= '0;
        cnt <= CW'(LOAD);
      end else if (en) begin
        pre <= next_pre(pre, last_tick);
        if (last_tick) cnt <= cnt - 1'b1;
      end
    end
  end

  // R5
  wdog_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> en) else $error("watchdog not re-armed by reset");
endmodule

// File: rtl/rsc_edge.sv
module rsc_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic toggled
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign toggled = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/rsc_arb.sv
module rsc_arb
  import rsc_pkg::*;
#(
  parameter int unsigned RST_LEN = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t req,
  output cause_t win,
  output logic   trig,
  output logic   busy
);
  localparam int unsigned LW = $clog2(RST_LEN + 1);

  logic [LW-1:0] left;

  assign busy = (left != '0);
  assign win  = busy ? '0 : pick_cause(req);
  assign trig = |win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left <= '0;
    else if (trig) left <= LW'(RST_LEN);
    else if (busy) left <= left - 1'b1;
  end

  // R10
  pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy) else $error("reset pulse too short");
endmodule

// File: rtl/reset_cause_hub.sv
module reset_cause_hub
  import rsc_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 12,
  parameter int unsigned WDT_LOAD = 15,
  parameter int unsigned RST_LEN  = 4
) (
  input  logic        clk,
  input  logic        pwr_rst_n,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        wdt_kick,
  input  logic        flash_err,
  input  logic        usb_func_en,
  input  logic        usb_bus_rst,
  input  logic        vbus,
  output logic        sys_rst,
  output logic [7:0]  stat_rdata
);
  cause_t req, win, stat_q;
  logic   busy, trig, wdt_expire, vbus_toggle;
  logic   wr_ok, stat_wr, ctrl_wr;
  logic   unused_wdata;

  assign wr_ok   = bus_we && !busy;
  assign stat_wr = wr_ok && !bus_addr;
  assign ctrl_wr = wr_ok &&  bus_addr;
  assign unused_wdata = ^{bus_wdata[6:5], bus_wdata[3:1]};

  rsc_wdog #(.DIV(CLK_DIV), .LOAD(WDT_LOAD)) u_wdog (
    .clk(clk), .rst_n(pwr_rst_n), .hold(busy || trig), .kick(wdt_kick),
    .cfg_we(ctrl_wr), .cfg_dis(bus_wdata[0]), .expire(wdt_expire));

  rsc_edge #(.STAGES(2)) u_vbus (
    .clk(clk), .rst_n(pwr_rst_n), .din(vbus), .toggled(vbus_toggle));

  always_comb begin
    req.wdt   = wdt_expire;
    req.flash = flash_err;
    req.sw    = stat_wr && bus_wdata[BIT_SW];
    req.usb   = stat_q.usb && ((usb_bus_rst && usb_func_en) || vbus_toggle);
  end

  rsc_arb #(.RST_LEN(RST_LEN)) u_arb (
    .clk(clk), .rst_n(pwr_rst_n), .req(req), .win(win), .trig(trig), .busy(busy));

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n)   stat_q     <= '0;
    else if (trig)    stat_q     <= win;
    else if (stat_wr) stat_q.usb <= bus_wdata[BIT_USB];
  end

  assign sys_rst    = busy;
  assign stat_rdata = pack_status(stat_q);

  // R7
  sw_req_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    req.sw |=> sys_rst) else $error("software request lost");
  // R3
  wdt_flag_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wdt_expire && !busy) |=> (sys_rst && stat_rdata[5])) else $error("watchdog flag missing");
  // R6
  flash_flag_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (flash_err && !busy && !wdt_expire) |=> stat_rdata[6]) else $error("flash flag missing");
  // R9
  vbus_rst_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (vbus_toggle && stat_q.usb && !busy) |=> sys_rst) else $error("vbus edge ignored");
  // R10
  stat_hold_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    sys_rst |=> $stable(stat_rdata)) else $error("status moved during pulse");
  // R11
  one_flag_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    $onehot0(stat_rdata[6:4])) else $error("several cause flags set");
endmodule

// File: tb/reset_cause_hub_tb.sv
`timescale 1ns/1ps
module reset_cause_hub_tb_top;
  localparam int DIV = 12;
  localparam int LOAD = 15;
  localparam int RLEN = 4;
  localparam int SPAN = DIV * (LOAD + 1);

  logic clk = 1'b0;
  logic pwr_rst_n = 1'b0;
  logic bus_we = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic wdt_kick = 1'b0, flash_err = 1'b0, usb_func_en = 1'b0, usb_bus_rst = 1'b0, vbus = 1'b0;
  logic sys_rst;
  logic [7:0] stat_rdata;

  int checks = 0, errs = 0, rises = 0, cyc = 0;

  always #4 clk = ~clk;

  reset_cause_hub #(.CLK_DIV(DIV), .WDT_LOAD(LOAD), .RST_LEN(RLEN)) dut_i (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wdt_kick(wdt_kick), .flash_err(flash_err),
    .usb_func_en(usb_func_en), .usb_bus_rst(usb_bus_rst), .vbus(vbus),
    .sys_rst(sys_rst), .stat_rdata(stat_rdata));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_left, m_pre, m_cnt, m_en, m_stat;
  bit vh[$];

  always @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      m_left = 0; m_pre = 0; m_cnt = LOAD; m_en = 1; m_stat = 0;
      vh = '{0, 0, 0};
    end else begin
      bit busy, swr, cwr, tog, expire, usbreq;
      int win, was_en;
      busy   = (m_left > 0);
      swr    = bus_we && !busy && !bus_addr;
      cwr    = bus_we && !busy && bus_addr;
      tog    = (vh[1] != vh[2]);
      expire = m_en && (m_pre == DIV - 1) && (m_cnt == 0);
      usbreq = m_stat[7] && ((usb_bus_rst && usb_func_en) || tog);
      win = 0;
      if (!busy) begin
        if (expire)                  win = 'h20;
        else if (flash_err)          win = 'h40;
        else if (swr && bus_wdata[4]) win = 'h10;
        else if (usbreq)             win = 'h80;
      end
      if (win != 0 || busy) begin
        m_left = (win != 0) ? RLEN : m_left - 1;
        if (win != 0) m_stat = win;
        m_en = 1; m_pre = 0; m_cnt = LOAD;
      end else begin
        if (swr) m_stat = (m_stat & 'h7f) | (bus_wdata & 'h80);
        was_en = m_en;
        if (cwr) m_en = !bus_wdata[0];
        if (wdt_kick) begin
          m_pre = 0; m_cnt = LOAD;
        end else if (was_en) begin
          if (m_pre == DIV - 1) begin m_pre = 0; m_cnt--; end
          else m_pre++;
        end
      end
      vh.push_front(vbus);
      void'(vh.pop_back());
    end
  end

  always @(posedge sys_rst) rises++;

  always @(negedge clk) begin
    cyc++;
    if (pwr_rst_n) begin
      chk("R10 sys_rst vs model", int'(sys_rst), int'(m_left > 0));
      chk("R3 status vs model", int'(stat_rdata), m_stat);
    end
    if (cyc > 100000) begin
      errs++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask
  task automatic kick();
    @(negedge clk); wdt_kick = 1'b1;
    @(negedge clk); wdt_kick = 1'b0;
  endtask
  task automatic wait_rise(int lim, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sys_rst && n < lim);
    if (!sys_rst) n = -1;
  endtask
  task automatic width(output int w);
    w = 0;
    while (sys_rst) begin w++; @(negedge clk); end
  endtask

  initial begin
    int n, w, r0;
    cycles(3);
    chk("R1 sys_rst in power reset", int'(sys_rst), 0);
    chk("R1 status in power reset", int'(stat_rdata), 0);
    pwr_rst_n = 1'b1;
    chk("R1 status after release", int'(stat_rdata), 0);
    // R2 expiry edge from power-up
    wait_rise(SPAN + 20, n);
    chk("R2 expiry edge", n, SPAN);
    width(w);
    chk("R10 pulse width", w, RLEN);
    chk("R3 watchdog flag", int'(stat_rdata), 'h20);
    // R4 periodic kicks
    r0 = rises;
    for (int i = 0; i < 5; i++) begin kick(); cycles(150); end
    chk("R4 no reset with kicks", rises, r0);
    // R5 disable, then software reset re-arms
    kick();
    wr(1'b1, 8'h01);
    cycles(500);
    chk("R5 disabled watchdog quiet", rises, r0);
    wr(1'b0, 8'h10);
    chk("R7 software reset raised", int'(sys_rst), 1);
    width(w);
    chk("R7 software flag", int'(stat_rdata), 'h10);
    wait_rise(SPAN + 20, n);
    chk("R5 re-armed expiry edge", n, SPAN);
    width(w);
    // R6 flash
    kick();
    @(negedge clk); flash_err = 1'b1;
    @(negedge clk); flash_err = 1'b0;
    chk("R6 flash reset raised", int'(sys_rst), 1);
    width(w);
    chk("R6 flash pulse width", w, RLEN);
    chk("R6 flash flag", int'(stat_rdata), 'h40);
    // R8 usb gating
    r0 = rises;
    usb_func_en = 1'b1;
    @(negedge clk); usb_bus_rst = 1'b1;
    @(negedge clk); usb_bus_rst = 1'b0;
    cycles(5);
    chk("R8 usb ignored when not selected", rises, r0);
    wr(1'b0, 8'h80);
    chk("R8 enable bit reads back", int'(stat_rdata), 'hC0);
    usb_func_en = 1'b0;
    @(negedge clk); usb_bus_rst = 1'b1;
    @(negedge clk); usb_bus_rst = 1'b0;
    cycles(5);
    chk("R8 bus reset needs function enable", rises, r0);
    usb_func_en = 1'b1;
    @(negedge clk); usb_bus_rst = 1'b1;
    @(negedge clk); usb_bus_rst = 1'b0;
    chk("R8 usb reset raised", int'(sys_rst), 1);
    width(w);
    chk("R8 usb flag", int'(stat_rdata), 'h80);
    // R9 vbus both edges
    kick();
    vbus = 1'b1;
    wait_rise(10, n);
    chk("R9 vbus rise latency", n, 3);
    width(w);
    chk("R9 usb flag after rise", int'(stat_rdata), 'h80);
    vbus = 1'b0;
    wait_rise(10, n);
    chk("R9 vbus fall latency", n, 3);
    width(w);
    // non-usb reset clears the enable
    @(negedge clk); flash_err = 1'b1;
    @(negedge clk); flash_err = 1'b0;
    width(w);
    chk("R8 enable cleared by flash reset", int'(stat_rdata), 'h40);
    r0 = rises;
    vbus = 1'b1;
    cycles(10);
    chk("R9 vbus ignored when not selected", rises, r0);
    // R10 cause during pulse
    kick();
    r0 = rises;
    wr(1'b0, 8'h10);
    flash_err = 1'b1;
    @(negedge clk); flash_err = 1'b0;
    width(w);
    chk("R10 width with flash in pulse", w + 1, RLEN);
    chk("R10 flag kept during pulse", int'(stat_rdata), 'h10);
    cycles(5);
    chk("R10 single pulse", rises, r0 + 1);
    // R11 simultaneous flash and software
    kick();
    @(negedge clk); bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h10; flash_err = 1'b1;
    @(negedge clk); bus_we = 1'b0; flash_err = 1'b0;
    width(w);
    chk("R11 priority flash over software", int'(stat_rdata), 'h40);
    cycles(4);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule